// File: doc/BRIEF.md
# I2C Host FIFO Register Port

This block is the register side of an I2C master controller that faces the host. The host reaches it with 64-bit accesses. The byte address carries the register index in its upper bits, and its three low bits must be zero. Through one data register the host pushes bytes that are to be sent, or pops bytes that the bus engine has received. Each such access is checked against the command the engine is running and against the busy state of the selected bus port. Every byte the host moves counts down a back-end residual that is loaded when a command starts.

Around the byte FIFO, the block holds:

- a mode register, which selects the bus port and the pacing policy;
- the status and extended status words, with their reset values;
- a per-port busy readout;
- a controller-reset register and an error-reset register.

The bus engine and the interrupt logic are separate blocks. The engine loads commands, moves bytes in and out of the FIFO and reports completion. This block in turn sends the engine a flush strobe and a controller-reset strobe.

Top module: `hfp_regport`

## Requirements
- R1: After reset, the status word (index 2) is 0x3700 for four ports: command-complete at bit 8, clock-line level at bit 9, data-line level at bit 10, ports minus one at bits 15:12, FIFO count 0 at bits 23:16, no errors at bits 2:0. The extended status word (index 3) is 0x0817: version 23 at bits 7:0 and FIFO depth 8 at bits 15:8. The residual (index 4) reads 0.
- R2: The register index is the byte address shifted right by three. Each of the following sets the invalid bit (status bit 0), changes nothing else and reads back 0: a nonzero address bit 2:0, an unknown index, a read of index 6 or 7, and a write to index 2, 3, 4 or 5.
- R3: A write to the FIFO register (index 0) is invalid, and stores no byte, when the selected bus is idle or the active command reads.
- R4: A read of the FIFO register is invalid when the selected bus is idle or the active command writes. It then returns the last popped byte unchanged.
- R5: A valid FIFO read returns the oldest byte in bits 7:0, with the upper bits zero. Bytes come out in arrival order.
- R6: When the pacing bit (mode bit 4) is clear, a write to a full FIFO or a read of an empty FIFO sets the overrun bit (status bit 1). The access completes, and the FIFO is left unchanged.
- R7: When the pacing bit is set, the same accesses hold host_wait high until space or data appears. They then complete normally, with no error.
- R8: Each host byte pushed or popped decrements the residual, which engine command loads set to the command length. If the residual is already 0, it stays 0 and the back-end error bit (status bit 2) is set instead.
- R9: flush_req pulses for one cycle right after each accepted host FIFO write, and at no other time.
- R10: A read of index 5 returns bus_busy, with bit i set when port i is busy.
- R11: A write to index 7 clears status bits 2:0, zeroes the residual, empties the FIFO and clears extended-status bit 16 (engine active). The version and depth fields stay as they are.
- R12: A write to index 6 restores every reset value of R1, clears the mode register and empties the FIFO. ctrl_reset pulses in the next cycle.
- R13: A write to the mode register (index 1, port at bits 3:0, pacing at bit 4) is invalid and leaves the mode unchanged while the selected bus is busy. Otherwise the mode register takes the new value.
- R14: host_ack and host_rdata belong to the cycle right after the edge that accepted the access. The status FIFO-count field shows the current FIFO occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, held while host_wait is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte address of the 64-bit register |
| host_wdata | input | 64 | Write data |
| host_wait | output | 1 | Access stalled by pacing |
| host_ack | output | 1 | Access completed on the previous edge |
| host_rdata | output | 64 | Read data, valid with host_ack |
| bus_busy | input | NPORTS | Busy state of each bus port |
| eng_cmd_load | input | 1 | Engine starts a command |
| eng_cmd_read | input | 1 | Direction of the command that is loading (1 = read) |
| eng_cmd_len | input | LEN_W | Byte count of the command that is loading |
| eng_done | input | 1 | Engine finished the command |
| eng_push | input | 1 | Engine stores a received byte |
| eng_push_data | input | 8 | Received byte |
| eng_pop | input | 1 | Engine takes the oldest byte to send |
| fifo_head | output | 8 | Oldest FIFO byte |
| fifo_count | output | CNT_W | FIFO occupancy |
| port_sel | output | 4 | Selected bus port |
| flush_req | output | 1 | Request for one engine flush step |
| ctrl_reset | output | 1 | Controller reset strobe to the engine |

## Verification
An access is accepted on the edge where host_req is high and host_wait is low. host_ack, host_rdata, flush_req and ctrl_reset all come from registers loaded on that edge, so each is due exactly one cycle after acceptance. Status, residual and mode updates take effect on the same edge, so they show in any later read. The bench drives on falling edges and checks host_wait a moment later, then samples ack and data on the falling edge after the accepting edge. It reads the strobe counters just after that falling edge, so each pulse has been counted once.

// File: rtl/hfp_pkg.sv
// Package: shared constants and types of the I2C host FIFO register port.
// Assumes a fixed 5-bit register index carried in address bits 7:3.
package hfp_pkg;
    localparam int IDX_W   = 5;
    localparam int HADDR_W = IDX_W + 3;

    localparam logic [IDX_W-1:0] RI_FIFO   = 5'd0;
    localparam logic [IDX_W-1:0] RI_MODE   = 5'd1;
    localparam logic [IDX_W-1:0] RI_STAT   = 5'd2;
    localparam logic [IDX_W-1:0] RI_XSTAT  = 5'd3;
    localparam logic [IDX_W-1:0] RI_RESID  = 5'd4;
    localparam logic [IDX_W-1:0] RI_PBUSY  = 5'd5;
    localparam logic [IDX_W-1:0] RI_CTLRST = 5'd6;
    localparam logic [IDX_W-1:0] RI_ERRRST = 5'd7;

    // status bit positions
    localparam int ST_INV  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_BKE  = 2;
    localparam int ST_CMDC = 8;
    localparam int ST_SCL  = 9;
    localparam int ST_SDA  = 10;
    localparam int ST_THR  = 12;
    localparam int ST_CNT  = 16;
    // extended status bit positions
    localparam int XS_VER    = 0;
    localparam int XS_DEPTH  = 8;
    localparam int XS_ACTIVE = 16;
    // mode bit positions
    localparam int MD_PACE = 4;

    typedef enum logic [3:0] {
        ACC_READ, ACC_MODE_WR, ACC_INVALID, ACC_OVERRUN, ACC_WAIT,
        ACC_PUSH, ACC_POP, ACC_ERR_RST, ACC_CTL_RST
    } acc_e;
endpackage

// File: rtl/hfp_fifo.sv
// Module: byte ring buffer shared by the host and the bus engine.
// Assumes DEPTH >= 2. A push into a full buffer is taken only when a pop
// happens in the same cycle; a pop from an empty buffer is ignored.
module hfp_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // flags and guarded operations
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        head    = mem[rptr];
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // storage write
    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wptr] <= push_data;
    end
endmodule

// File: rtl/hfp_residual.sv
// Module: back-end residual byte counter.
// Clear beats load, load beats decrement; decrement at zero is ignored.
module hfp_residual #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic [LEN_W-1:0] value,
    output logic             zero
);
    // zero detect
    always_comb zero = (value == '0);

    // counter update
    always_ff @(posedge clk) begin
        if (!rst_n || clear)   value <= '0;
        else if (load)         value <= load_val;
        else if (dec && !zero) value <= value - LEN_W'(1);
    end
endmodule

// File: rtl/hfp_access_check.sv
// Module: classifies one host access into an action.
// Purely combinational; assumes its inputs reflect state before the edge.
module hfp_access_check
    import hfp_pkg::*;
(
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             misaligned,
    input  logic             sel_busy,
    input  logic             cmd_read,
    input  logic             pace,
    input  logic             full,
    input  logic             empty,
    output acc_e             kind
);
    // decision per register index
    always_comb begin
        kind = ACC_INVALID;
        if (!misaligned) begin
            case (idx)
                RI_FIFO: begin
                    if (!sel_busy || (cmd_read == we)) kind = ACC_INVALID;
                    else if (we ? full : empty)        kind = pace ? ACC_WAIT : ACC_OVERRUN;
                    else                               kind = we ? ACC_PUSH : ACC_POP;
                end
                RI_MODE: begin
                    if (!we)          kind = ACC_READ;
                    else if (sel_busy) kind = ACC_INVALID;
                    else              kind = ACC_MODE_WR;
                end
                RI_STAT, RI_XSTAT, RI_RESID, RI_PBUSY:
                    kind = we ? ACC_INVALID : ACC_READ;
                RI_CTLRST: kind = we ? ACC_CTL_RST : ACC_INVALID;
                RI_ERRRST: kind = we ? ACC_ERR_RST : ACC_INVALID;
                default:   kind = ACC_INVALID;
            endcase
        end
    end
endmodule

// File: rtl/hfp_regport.sv
// Module: host register port of an I2C master (top).
// Assumes NPORTS <= 16, FIFO_DEPTH in 2..255, and that the engine pushes
// only when the FIFO has room and pops only when it holds data.
module hfp_regport
    import hfp_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 16,
    parameter int VERSION    = 23,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int PSEL_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic               host_wait,
    output logic               host_ack,
    output logic [63:0]        host_rdata,
    input  logic [NPORTS-1:0]  bus_busy,
    input  logic               eng_cmd_load,
    input  logic               eng_cmd_read,
    input  logic [LEN_W-1:0]   eng_cmd_len,
    input  logic               eng_done,
    input  logic               eng_push,
    input  logic [7:0]         eng_push_data,
    input  logic               eng_pop,
    output logic [7:0]         fifo_head,
    output logic [CNT_W-1:0]   fifo_count,
    output logic [3:0]         port_sel,
    output logic               flush_req,
    output logic               ctrl_reset
);
    localparam logic [3:0] NPORTS_L = 4'(NPORTS);

    logic [IDX_W-1:0] idx;
    logic             misaligned, sel_busy, accept;
    logic             pace_r, cmd_read_r, cmd_comp_r, active_r;
    logic [3:0]       port_r;
    logic [2:0]       err_r;
    logic [7:0]       fifo_data_r;
    logic             fifo_full, fifo_empty, host_push, host_pop;
    logic             err_rst, ctl_rst;
    logic [LEN_W-1:0] resid;
    logic             resid_zero;
    logic [63:0]      rd_data, stat_word, xstat_word;
    acc_e             kind;
    logic             unused_wdata;

    assign unused_wdata = ^host_wdata[63:8] ^ host_wdata[7] ^ host_wdata[6] ^ host_wdata[5];

    // address split and selected-port busy lookup
    always_comb begin
        idx        = host_addr[HADDR_W-1:3];
        misaligned = (host_addr[2:0] != 3'b000);
        sel_busy   = (port_r < NPORTS_L) ? bus_busy[port_r[PSEL_W-1:0]] : 1'b0;
    end

    hfp_access_check u_check (
        .we         (host_we),
        .idx        (idx),
        .misaligned (misaligned),
        .sel_busy   (sel_busy),
        .cmd_read   (cmd_read_r),
        .pace       (pace_r),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .kind       (kind)
    );

    // acceptance and per-action strobes
    always_comb begin
        host_wait = host_req && (kind == ACC_WAIT);
        accept    = host_req && (kind != ACC_WAIT);
        host_push = accept && (kind == ACC_PUSH);
        host_pop  = accept && (kind == ACC_POP);
        err_rst   = accept && (kind == ACC_ERR_RST);
        ctl_rst   = accept && (kind == ACC_CTL_RST);
        port_sel  = port_r;
    end

    hfp_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (err_rst || ctl_rst),
        .push      (host_push || eng_push),
        .push_data (host_push ? host_wdata[7:0] : eng_push_data),
        .pop       (host_pop || eng_pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    hfp_residual #(.LEN_W(LEN_W)) u_resid (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (err_rst || ctl_rst),
        .load     (eng_cmd_load),
        .load_val (eng_cmd_len),
        .dec      (host_push || host_pop),
        .value    (resid),
        .zero     (resid_zero)
    );

    // status and extended status words as seen by a read
    always_comb begin
        stat_word                    = '0;
        stat_word[ST_BKE:ST_INV]     = err_r;
        stat_word[ST_CMDC]           = cmd_comp_r;
        stat_word[ST_SCL]            = 1'b1;
        stat_word[ST_SDA]            = 1'b1;
        stat_word[ST_THR+:4]         = 4'(NPORTS - 1);
        stat_word[ST_CNT+:8]         = 8'(fifo_count);
        xstat_word                   = '0;
        xstat_word[XS_VER+:8]        = 8'(VERSION);
        xstat_word[XS_DEPTH+:8]      = 8'(FIFO_DEPTH);
        xstat_word[XS_ACTIVE]        = active_r;
    end

    // read data selection
    always_comb begin
        rd_data = '0;
        if (!host_we) begin
            if (kind == ACC_POP)
                rd_data = {56'd0, fifo_head};
            else if (idx == RI_FIFO && !misaligned)
                rd_data = {56'd0, fifo_data_r};
            else if (kind == ACC_READ) begin
                case (idx)
                    RI_MODE:  rd_data = 64'({pace_r, port_r});
                    RI_STAT:  rd_data = stat_word;
                    RI_XSTAT: rd_data = xstat_word;
                    RI_RESID: rd_data = 64'(resid);
                    RI_PBUSY: rd_data = 64'(bus_busy);
                    default:  rd_data = '0;
                endcase
            end
        end
    end

    // control state: mode, errors, command direction and progress
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_rst) begin
            port_r      <= '0;
            pace_r      <= 1'b0;
            err_r       <= '0;
            cmd_read_r  <= 1'b0;
            cmd_comp_r  <= 1'b1;
            active_r    <= 1'b0;
            fifo_data_r <= '0;
        end else begin
            if (eng_cmd_load) begin
                cmd_read_r <= eng_cmd_read;
                cmd_comp_r <= 1'b0;
                active_r   <= 1'b1;
            end
            if (eng_done) begin
                cmd_comp_r <= 1'b1;
                active_r   <= 1'b0;
            end
            if (err_rst) begin
                err_r    <= '0;
                active_r <= 1'b0;
            end
            if (accept) begin
                case (kind)
                    ACC_INVALID: err_r[ST_INV] <= 1'b1;
                    ACC_OVERRUN: err_r[ST_OVR] <= 1'b1;
                    ACC_PUSH, ACC_POP: if (resid_zero) err_r[ST_BKE] <= 1'b1;
                    ACC_MODE_WR: begin
                        port_r <= host_wdata[3:0];
                        pace_r <= host_wdata[MD_PACE];
                    end
                    default: ;
                endcase
            end
            if (host_pop) fifo_data_r <= fifo_head;
        end
    end

    // host response and engine strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
            flush_req  <= 1'b0;
            ctrl_reset <= 1'b0;
        end else begin
            host_ack   <= accept;
            host_rdata <= accept ? rd_data : '0;
            flush_req  <= host_push;
            ctrl_reset <= ctl_rst;
        end
    end
endmodule

// File: rtl/hfp_regport_checker.sv
// Module: protocol assertions for hfp_regport, attached by bind.
// Assumes it sees the top's internal pacing bit and residual-zero flag.
module hfp_regport_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_req,
    input logic             host_we,
    input logic             host_wait,
    input logic             host_ack,
    input logic             flush_req,
    input logic             ctrl_reset,
    input logic             eng_cmd_load,
    input logic             pace,
    input logic             resid_zero,
    input logic [CNT_W-1:0] fifo_count
);
    AST_WAIT_NEEDS_PACE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait |-> pace); // R7
    AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past(host_req && !host_wait)); // R14
    AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(host_req && host_we && !host_wait)); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH)); // R6
    AST_RESID_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resid_zero && !eng_cmd_load) |=> resid_zero); // R8
    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset |-> (fifo_count == '0 && !pace)); // R12
endmodule

bind hfp_regport hfp_regport_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_wait    (host_wait),
    .host_ack     (host_ack),
    .flush_req    (flush_req),
    .ctrl_reset   (ctrl_reset),
    .eng_cmd_load (eng_cmd_load),
    .pace         (pace_r),
    .resid_zero   (resid_zero),
    .fifo_count   (fifo_count)
);

// File: tb/hfp_regport_test.sv
// Bench: table-driven register walk, then directed FIFO, pacing and reset tests.
module hfp_regport_test;
    localparam int NPORTS = 4;
    localparam int CNT_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 0, host_we = 0;
    logic [7:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic host_wait, host_ack;
    logic [63:0] host_rdata;
    logic [NPORTS-1:0] bus_busy = '0;
    logic eng_cmd_load = 0, eng_cmd_read = 0, eng_done = 0, eng_push = 0, eng_pop = 0;
    logic [15:0] eng_cmd_len = '0;
    logic [7:0] eng_push_data = '0;
    logic [7:0] fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic [3:0] port_sel;
    logic flush_req, ctrl_reset;

    int checks = 0, errors = 0, flush_cnt = 0, ctl_cnt = 0;

    always #4 clk = ~clk;

    hfp_regport uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_wait(host_wait),
        .host_ack(host_ack), .host_rdata(host_rdata), .bus_busy(bus_busy),
        .eng_cmd_load(eng_cmd_load), .eng_cmd_read(eng_cmd_read),
        .eng_cmd_len(eng_cmd_len), .eng_done(eng_done), .eng_push(eng_push),
        .eng_push_data(eng_push_data), .eng_pop(eng_pop), .fifo_head(fifo_head),
        .fifo_count(fifo_count), .port_sel(port_sel), .flush_req(flush_req),
        .ctrl_reset(ctrl_reset)
    );

    // strobe counters sampled away from the active edge
    always @(negedge clk) begin
        if (flush_req)  flush_cnt++;
        if (ctrl_reset) ctl_cnt++;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] addr, input logic [63:0] wd,
                          output logic [63:0] rd, output int waited);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd; waited = 0;
        #1;
        while (host_wait && waited < 1000) begin
            @(negedge clk); #1; waited++;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R14 ack one cycle after accept", host_ack, 1'b1);
        rd = host_rdata;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic eng_load(input logic rd, input logic [15:0] len);
        @(negedge clk); eng_cmd_load = 1; eng_cmd_read = rd; eng_cmd_len = len;
        @(negedge clk); eng_cmd_load = 0;
    endtask
    task automatic eng_push1(input logic [7:0] d);
        @(negedge clk); eng_push = 1; eng_push_data = d;
        @(negedge clk); eng_push = 0;
    endtask
    task automatic eng_pop1();
        @(negedge clk); eng_pop = 1;
        @(negedge clk); eng_pop = 0;
    endtask
    task automatic eng_done1();
        @(negedge clk); eng_done = 1;
        @(negedge clk); eng_done = 0;
    endtask

    // {we, addr, wdata, expected rdata, requirement}
    localparam int NVEC = 19;
    localparam logic [60:0] VEC [NVEC] = '{
        {1'b0, 8'h10, 16'h0000, 32'h3700, 4'd1},   // R1 status reset
        {1'b0, 8'h18, 16'h0000, 32'h0817, 4'd1},   // R1 extended status
        {1'b0, 8'h20, 16'h0000, 32'h0000, 4'd1},   // R1 residual
        {1'b1, 8'h08, 16'h0012, 32'h0000, 4'd13},  // R13 mode write idle
        {1'b0, 8'h08, 16'h0000, 32'h0012, 4'd13},
        {1'b1, 8'h08, 16'h0001, 32'h0000, 4'd13},
        {1'b0, 8'h08, 16'h0000, 32'h0001, 4'd13},
        {1'b0, 8'h28, 16'h0000, 32'h0000, 4'd10},  // R10 all idle
        {1'b0, 8'h30, 16'h0000, 32'h0000, 4'd2},   // R2 read of write-only
        {1'b0, 8'h10, 16'h0000, 32'h3701, 4'd2},
        {1'b1, 8'h38, 16'h0000, 32'h0000, 4'd11},  // R11 error reset
        {1'b0, 8'h10, 16'h0000, 32'h3700, 4'd11},
        {1'b1, 8'h10, 16'h00FF, 32'h0000, 4'd2},   // R2 write to read-only
        {1'b0, 8'h10, 16'h0000, 32'h3701, 4'd2},
        {1'b1, 8'h38, 16'h0000, 32'h0000, 4'd11},
        {1'b0, 8'h0C, 16'h0000, 32'h0000, 4'd2},   // R2 misaligned address
        {1'b0, 8'h10, 16'h0000, 32'h3701, 4'd2},
        {1'b1, 8'h38, 16'h0000, 32'h0000, 4'd11},
        {1'b0, 8'h10, 16'h0000, 32'h3700, 4'd11}
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] rd;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack idle after reset", host_ack, 0);
        chk("R1 fifo empty after reset", fifo_count, 0);
        chk("R1 port select after reset", port_sel, 0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][60], VEC[i][59:52], 64'(VEC[i][51:36]), rd, w);
            chk($sformatf("R%0d table entry %0d", VEC[i][3:0], i), rd, 64'(VEC[i][35:4]));
        end

        // R3: write with bus idle
        access(1, 8'h00, 64'hAA, rd, w);
        access(0, 8'h10, 0, rd, w);
        chk("R3 write while idle invalid", rd, 64'h3701);
        chk("R3 no byte stored", fifo_count, 0);
        access(1, 8'h38, 0, rd, w);
        bus_busy = 4'b0010;
        // R3: write during read command
        eng_load(1, 3);
        access(1, 8'h00, 64'hAB, rd, w);
        access(0, 8'h10, 0, rd, w);
        chk("R3 write during read command invalid", rd[2:0], 3'b001);
        chk("R3 no byte stored on read command", fifo_count, 0);
        access(1, 8'h38, 0, rd, w);
        // R4: read during write command
        eng_load(0, 3);
        access(0, 8'h00, 0, rd, w);
        chk("R4 read data unchanged", rd, 0);
        access(0, 8'h10, 0, rd, w);
        chk("R4 read during write command invalid", rd[2:0], 3'b001);
        access(1, 8'h38, 0, rd, w);

        // R5, R8, R6 read path
        eng_load(1, 3);
        access(0, 8'h10, 0, rd, w);
        chk("R1 command-complete clears on load", rd, 64'h3600);
        eng_push1(8'h11); eng_push1(8'h22); eng_push1(8'h33);
        access(0, 8'h10, 0, rd, w);
        chk("R14 count field", rd, 64'h33600);
        access(0, 8'h00, 0, rd, w); chk("R5 first byte", rd, 64'h11);
        access(0, 8'h00, 0, rd, w); chk("R5 second byte", rd, 64'h22);
        access(0, 8'h20, 0, rd, w); chk("R8 residual after two", rd, 1);
        access(0, 8'h00, 0, rd, w); chk("R5 third byte", rd, 64'h33);
        access(0, 8'h20, 0, rd, w); chk("R8 residual zero", rd, 0);
        eng_push1(8'h44);
        access(0, 8'h00, 0, rd, w); chk("R5 byte past residual", rd, 64'h44);
        access(0, 8'h10, 0, rd, w); chk("R8 back-end error", rd, 64'h3604);
        access(0, 8'h20, 0, rd, w); chk("R8 residual stays zero", rd, 0);
        access(0, 8'h00, 0, rd, w); chk("R6 empty read keeps data", rd, 64'h44);
        access(0, 8'h10, 0, rd, w); chk("R6 overrun on empty read", rd[2:0], 3'b110);
        access(1, 8'h38, 0, rd, w);
        eng_done1();
        access(0, 8'h10, 0, rd, w); chk("R11 status after clear and done", rd, 64'h3700);

        // R7 paced read
        bus_busy = 4'b0000;
        access(1, 8'h08, 64'h11, rd, w);
        bus_busy = 4'b0010;
        eng_load(1, 2);
        fork
            access(0, 8'h00, 0, rd, w);
            begin repeat (3) @(negedge clk); eng_push1(8'h5A); end
        join
        chk("R7 paced read data", rd, 64'h5A);
        chk("R7 paced read waited", 64'(w >= 3), 1);
        access(0, 8'h10, 0, rd, w); chk("R7 no error after paced read", rd[2:0], 0);

        // R7/R9 paced write
        eng_load(0, 10);
        flush_cnt = 0;
        for (int i = 0; i < 8; i++) access(1, 8'h00, 64'(8'h10 + i), rd, w);
        #1;
        chk("R9 one flush per write", flush_cnt, 8);
        chk("R7 fifo full", fifo_count, 8);
        chk("R5 head is oldest", fifo_head, 8'h10);
        fork
            access(1, 8'h00, 64'h99, rd, w);
            begin repeat (2) @(negedge clk); eng_pop1(); end
        join
        #1;
        chk("R7 paced write waited", 64'(w >= 2), 1);
        chk("R7 fifo full again", fifo_count, 8);
        chk("R5 head after engine pop", fifo_head, 8'h11);
        chk("R9 flush after paced write", flush_cnt, 9);
        access(0, 8'h20, 0, rd, w); chk("R8 residual after nine", rd, 1);

        // R6 write overrun
        bus_busy = 4'b0000;
        access(1, 8'h08, 64'h01, rd, w);
        bus_busy = 4'b0010;
        access(1, 8'h00, 64'h77, rd, w);
        #1;
        chk("R9 no flush on overrun", flush_cnt, 9);
        chk("R6 count unchanged", fifo_count, 8);
        access(0, 8'h10, 0, rd, w); chk("R6 overrun on full write", rd[2:0], 3'b010);

        // R13 mode write while busy
        access(1, 8'h08, 64'h13, rd, w);
        access(0, 8'h08, 0, rd, w); chk("R13 mode unchanged while busy", rd, 64'h01);
        access(0, 8'h10, 0, rd, w); chk("R13 invalid set", rd[2:0], 3'b011);

        // R10 port busy readout
        bus_busy = 4'b1010;
        access(0, 8'h28, 0, rd, w); chk("R10 port busy bits", rd, 64'hA);

        // R11 error reset
        access(0, 8'h18, 0, rd, w); chk("R11 engine active before clear", rd, 64'h10817);
        access(1, 8'h38, 0, rd, w);
        access(0, 8'h10, 0, rd, w); chk("R11 status cleared", rd, 64'h3600);
        access(0, 8'h20, 0, rd, w); chk("R11 residual zero", rd, 0);
        access(0, 8'h18, 0, rd, w); chk("R11 extended keeps fields", rd, 64'h0817);
        chk("R11 fifo empty", fifo_count, 0);

        // R12 controller reset
        access(1, 8'h00, 64'h5, rd, w);
        access(1, 8'h30, 0, rd, w);
        #1;
        chk("R12 ctrl_reset pulse", ctl_cnt, 1);
        chk("R12 fifo empty", fifo_count, 0);
        access(0, 8'h08, 0, rd, w); chk("R12 mode cleared", rd, 0);
        access(0, 8'h10, 0, rd, w); chk("R12 status reset value", rd, 64'h3700);
        access(0, 8'h18, 0, rd, w); chk("R12 extended reset value", rd, 64'h0817);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule